// File: doc/BRIEF.md
# Sector Single-Bit ECC Checker

This block judges the outcome of a single-error-correcting parity check on a 512-byte data sector. It takes the code word kept with the sector (24 bits, already in stored form) and the raw 32-bit parity value that a separate engine produced while the sector was read back. It packs and inverts the raw value into the same 24-bit stored form, XORs the two words into a syndrome, and classifies the syndrome: clean, one flipped data bit that can be repaired, one flipped bit inside the code word, or damage beyond repair. Because the stored form is inverted, an erased sector (all data and code bytes at 0xFF, raw parity zero) checks clean.

For a repairable data bit the block reports the byte offset and bit index. When repair is enabled it performs a read-modify-write on an attached sector buffer port to flip that bit. The packed stored form of the raw parity is also available at all times, for use when writing a sector. Computing the parity over the data stream is not part of this block.

A check is started by a one-cycle `start` strobe. There is no back-pressure: `start` is accepted only while the block is idle and is ignored while a check is in progress. The buffer port has fixed timing and no handshake: the buffer must return read data in the same cycle as the address and must accept a write on the clock edge that ends the write cycle.

Top module: `sector_ecc_checker`

## Requirements
- R1: `packed_code` equals the bitwise inverse of {raw_parity[27:16], raw_parity[11:0]}. The reserved raw bits 31:28 and 15:12 have no effect on it or on any result.
- R2: The syndrome is `stored_code` XOR `packed_code`. A zero syndrome gives status 2'b00 (none), makes no buffer write, and pulses `done` in the cycle after `start` is sampled.
- R3: When syndrome[23:12] XOR syndrome[11:0] equals 12'hFFF and the offset is inside the sector, the status is 2'b01 (corrected), `err_byte` = syndrome[23:15] and `err_bit` = syndrome[14:12].
- R4: For status 2'b01 with `fix_en` high, the cycle after `start` drives `buf_we` for one cycle with `buf_addr` = `err_byte` and `buf_wdata` = `buf_rdata` with bit `err_bit` inverted. `done` follows in the next cycle.
- R5: With `fix_en` low, a corrected result makes no buffer write, and `done` comes in the cycle after `start`.
- R6: A syndrome with exactly one bit set gives status 2'b10 (code-bit error) and no buffer write.
- R7: Any other nonzero syndrome gives status 2'b11 (uncorrectable) and no buffer write.
- R8: A repairable pattern whose byte offset is not below SECTOR_BYTES gives status 2'b11.
- R9: `done` is a single-cycle pulse. A `start` raised while a check is in progress is ignored. Results hold until the next accepted `start`.
- R10: After reset, `done`, `buf_we` and `status` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle strobe that begins a check |
| fix_en | input | 1 | Allows the repair write to the buffer |
| stored_code | input | 24 | Code word kept with the sector, in stored form |
| raw_parity | input | 32 | Raw parity value from the parity engine |
| packed_code | output | 24 | Stored form of raw_parity |
| done | output | 1 | One-cycle pulse when the result is valid |
| status | output | 2 | 00 none, 01 corrected, 10 code-bit error, 11 uncorrectable |
| err_byte | output | 9 | Byte offset of the repairable bit |
| err_bit | output | 3 | Bit index of the repairable bit |
| buf_addr | output | 9 | Sector buffer byte address |
| buf_we | output | 1 | Sector buffer write enable |
| buf_wdata | output | 8 | Sector buffer write data |
| buf_rdata | input | 8 | Sector buffer read data (same cycle as address) |

## Verification
A wrong latched classification shows at `status` in the same cycle as `done`. That is one cycle after `start` for most cases, and two cycles after `start` when a repair write takes place. A sequencer in the wrong state shows up at the ports as a missing, doubled or late `done` pulse, or as a `buf_we` where none belongs. A wrong bit index shows up one cycle later as a buffer byte that differs from the expected single-bit flip. A second instance with a 256-byte sector exercises the out-of-range offset rule, which cannot occur at the default size.

// File: rtl/ecc_chk_pkg.sv
package ecc_chk_pkg;

  localparam int RAW_W      = 32;
  localparam int HALF_W     = 12;
  localparam int FIELD_GAP  = 16;
  localparam int CODE_W     = 2 * HALF_W;
  localparam int BIT_IDX_W  = 3;
  localparam int BYTE_IDX_W = HALF_W - BIT_IDX_W;
  localparam int DATA_W     = 1 << BIT_IDX_W;

  typedef enum logic [1:0] {
    ECC_NONE   = 2'b00,
    ECC_FIXED  = 2'b01,
    ECC_CODE   = 2'b10,
    ECC_FATAL  = 2'b11
  } ecc_status_e;

  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'b00,
    SEQ_WRITE  = 2'b01,
    SEQ_REPORT = 2'b10
  } seq_state_e;

endpackage

// File: rtl/ecc_code_pack.sv
module ecc_code_pack
  import ecc_chk_pkg::*;
(
  input  logic [RAW_W-1:0]  raw,
  output logic [CODE_W-1:0] code
);

  logic [CODE_W-1:0] joined;

  for (genvar h = 0; h < 2; h++) begin : g_half
    assign joined[h*HALF_W +: HALF_W] = raw[h*FIELD_GAP +: HALF_W];
  end

  // Reserved raw bits feed nothing.
  logic reserved_unused;
  assign reserved_unused = ^{raw[FIELD_GAP-1:HALF_W], raw[RAW_W-1:FIELD_GAP+HALF_W]};

  // Inverted so an erased sector (raw parity zero) matches all-ones storage.
  assign code = ~joined;

endmodule

// File: rtl/ecc_syndrome_classify.sv
module ecc_syndrome_classify
  import ecc_chk_pkg::*;
#(
  parameter int SECTOR_BYTES = 512
) (
  input  logic [CODE_W-1:0]     stored,
  input  logic [CODE_W-1:0]     calc,
  output ecc_status_e           status,
  output logic [BYTE_IDX_W-1:0] byte_idx,
  output logic [BIT_IDX_W-1:0]  bit_idx
);

  localparam logic [BYTE_IDX_W:0] LIMIT = (BYTE_IDX_W+1)'(SECTOR_BYTES);

  logic [CODE_W-1:0] syn;
  logic [HALF_W-1:0] hi_half, lo_half;
  logic              pair_ok, in_range;

  always_comb begin
    syn      = stored ^ calc;
    hi_half  = syn[CODE_W-1:HALF_W];
    lo_half  = syn[HALF_W-1:0];
    pair_ok  = (hi_half ^ lo_half) == {HALF_W{1'b1}};
    byte_idx = hi_half[HALF_W-1:BIT_IDX_W];
    bit_idx  = hi_half[BIT_IDX_W-1:0];
    in_range = {1'b0, byte_idx} < LIMIT;

    if (syn == '0)            status = ECC_NONE;
    else if (pair_ok)         status = in_range ? ECC_FIXED : ECC_FATAL;
    else if ($onehot(syn))    status = ECC_CODE;
    else                      status = ECC_FATAL;
  end

  // R8: a repair is never offered outside the sector
  always_comb begin
    if (status == ECC_FIXED) begin
      p_fix_in_sector_r8: assert ({1'b0, byte_idx} < LIMIT);
    end
  end

endmodule

// File: rtl/ecc_fix_seq.sv
module ecc_fix_seq
  import ecc_chk_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  localparam int ADDR_W = $clog2(SECTOR_BYTES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  fix_en,
  input  ecc_status_e           cls_status,
  input  logic [BYTE_IDX_W-1:0] cls_byte,
  input  logic [BIT_IDX_W-1:0]  cls_bit,
  output logic                  done,
  output ecc_status_e           status,
  output logic [BYTE_IDX_W-1:0] err_byte,
  output logic [BIT_IDX_W-1:0]  err_bit,
  output logic [ADDR_W-1:0]     buf_addr,
  output logic                  buf_we,
  output logic [DATA_W-1:0]     buf_wdata,
  input  logic [DATA_W-1:0]     buf_rdata
);

  seq_state_e state;
  logic       want_write;

  assign want_write = (cls_status == ECC_FIXED) && fix_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= SEQ_IDLE;
      status   <= ECC_NONE;
      err_byte <= '0;
      err_bit  <= '0;
    end else begin
      unique case (state)
        SEQ_IDLE: begin
          if (start) begin
            status   <= cls_status;
            err_byte <= cls_byte;
            err_bit  <= cls_bit;
            state    <= want_write ? SEQ_WRITE : SEQ_REPORT;
          end
        end
        SEQ_WRITE:  state <= SEQ_REPORT;
        SEQ_REPORT: state <= SEQ_IDLE;
        default:    state <= SEQ_IDLE;
      endcase
    end
  end

  assign done      = (state == SEQ_REPORT);
  assign buf_we    = (state == SEQ_WRITE);
  assign buf_addr  = err_byte[ADDR_W-1:0];
  assign buf_wdata = buf_rdata ^ (DATA_W'(1) << err_bit);

  // R9: done lasts exactly one cycle
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4: the repair write is one cycle and is followed by done
  p_write_then_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |=> (done && !buf_we));

  // R4/R6/R7: only a corrected result may write the buffer
  p_write_only_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> (status == ECC_FIXED));

  // R2: without a write, done comes one cycle after an accepted start
  p_done_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && state == SEQ_IDLE && !want_write) |=> done);

  // R9: results hold while no start is given
  p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(status));

endmodule

// File: rtl/sector_ecc_checker.sv
module sector_ecc_checker
  import ecc_chk_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  localparam int ADDR_W = $clog2(SECTOR_BYTES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  fix_en,
  input  logic [CODE_W-1:0]     stored_code,
  input  logic [RAW_W-1:0]      raw_parity,
  output logic [CODE_W-1:0]     packed_code,
  output logic                  done,
  output logic [1:0]            status,
  output logic [BYTE_IDX_W-1:0] err_byte,
  output logic [BIT_IDX_W-1:0]  err_bit,
  output logic [ADDR_W-1:0]     buf_addr,
  output logic                  buf_we,
  output logic [DATA_W-1:0]     buf_wdata,
  input  logic [DATA_W-1:0]     buf_rdata
);

  ecc_status_e           cls_status, seq_status;
  logic [BYTE_IDX_W-1:0] cls_byte;
  logic [BIT_IDX_W-1:0]  cls_bit;

  ecc_code_pack u_pack (
    .raw  (raw_parity),
    .code (packed_code)
  );

  ecc_syndrome_classify #(.SECTOR_BYTES(SECTOR_BYTES)) u_classify (
    .stored   (stored_code),
    .calc     (packed_code),
    .status   (cls_status),
    .byte_idx (cls_byte),
    .bit_idx  (cls_bit)
  );

  ecc_fix_seq #(.SECTOR_BYTES(SECTOR_BYTES)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .fix_en     (fix_en),
    .cls_status (cls_status),
    .cls_byte   (cls_byte),
    .cls_bit    (cls_bit),
    .done       (done),
    .status     (seq_status),
    .err_byte   (err_byte),
    .err_bit    (err_bit),
    .buf_addr   (buf_addr),
    .buf_we     (buf_we),
    .buf_wdata  (buf_wdata),
    .buf_rdata  (buf_rdata)
  );

  assign status = seq_status;

endmodule

// File: tb/sector_ecc_checker_bench.sv
module sector_ecc_checker_bench;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [23:0] stored;
    logic [31:0] raw;
    logic        fix;
    logic [1:0]  st;
    logic [8:0]  byte_i;
    logic [2:0]  bit_i;
  } vec_t;

  // raw 0ABC0123 packs to 543EDC; stored = syndrome ^ 543EDC
  localparam int NVEC = 11;
  localparam vec_t VECS [NVEC] = '{
    '{24'h543EDC, 32'h0ABC0123, 1'b1, 2'b00, 9'd0,   3'd0},  // R2 clean
    '{24'h568108, 32'h0ABC0123, 1'b1, 2'b01, 9'd5,   3'd3},  // R3 R4
    '{24'hABCEDC, 32'h0ABC0123, 1'b1, 2'b01, 9'd511, 3'd7},  // R3 last byte
    '{24'h543123, 32'h0ABC0123, 1'b0, 2'b01, 9'd0,   3'd0},  // R5 no repair
    '{24'h543EDD, 32'h0ABC0123, 1'b1, 2'b10, 9'd0,   3'd0},  // R6 low bit
    '{24'hD43EDC, 32'h0ABC0123, 1'b1, 2'b10, 9'd0,   3'd0},  // R6 top bit
    '{24'h543EDF, 32'h0ABC0123, 1'b1, 2'b11, 9'd0,   3'd0},  // R7 two bits
    '{24'hABC123, 32'h0ABC0123, 1'b1, 2'b11, 9'd0,   3'd0},  // R7 all ones
    '{24'hFFFFFF, 32'hF000F000, 1'b1, 2'b00, 9'd0,   3'd0},  // R1 erased
    '{24'h568108, 32'hFABCF123, 1'b1, 2'b01, 9'd5,   3'd3},  // R1 reserved bits
    '{24'hC21841, 32'h0ABC0123, 1'b1, 2'b01, 9'd300, 3'd2}   // R4 mid sector
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        fix_en = 1'b0;
  logic [23:0] stored_code = '0;
  logic [31:0] raw_parity = '0;
  logic [23:0] packed_code, packed_s;
  logic        done, done_s;
  logic [1:0]  status, status_s;
  logic [8:0]  err_byte, err_byte_s;
  logic [2:0]  err_bit, err_bit_s;
  logic [8:0]  buf_addr;
  logic [7:0]  buf_addr_s;
  logic        buf_we, buf_we_s;
  logic [7:0]  buf_wdata, buf_wdata_s, buf_rdata;
  logic [7:0]  mem [512];

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign buf_rdata = mem[buf_addr];
  always @(posedge clk) if (buf_we) mem[buf_addr] <= buf_wdata;

  sector_ecc_checker u_sector_ecc_checker (
    .clk(clk), .rst_n(rst_n), .start(start), .fix_en(fix_en),
    .stored_code(stored_code), .raw_parity(raw_parity), .packed_code(packed_code),
    .done(done), .status(status), .err_byte(err_byte), .err_bit(err_bit),
    .buf_addr(buf_addr), .buf_we(buf_we), .buf_wdata(buf_wdata), .buf_rdata(buf_rdata)
  );

  sector_ecc_checker #(.SECTOR_BYTES(256)) u_sector_ecc_checker_small (
    .clk(clk), .rst_n(rst_n), .start(start), .fix_en(1'b0),
    .stored_code(stored_code), .raw_parity(raw_parity), .packed_code(packed_s),
    .done(done_s), .status(status_s), .err_byte(err_byte_s), .err_bit(err_bit_s),
    .buf_addr(buf_addr_s), .buf_we(buf_we_s), .buf_wdata(buf_wdata_s), .buf_rdata(8'h00)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // Drive one check; report the done latency and any buffer write seen.
  task automatic run_op(input logic [23:0] s, input logic [31:0] r, input logic f,
                        output int lat, output bit we_seen, output logic [8:0] we_addr);
    @(negedge clk);
    stored_code = s; raw_parity = r; fix_en = f; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0; we_seen = 0; we_addr = '0;
    for (int c = 1; c <= 3; c++) begin
      if (buf_we) begin we_seen = 1; we_addr = buf_addr; end
      if (done) begin lat = c; break; end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    int lat;
    bit we_seen;
    logic [8:0] we_addr;
    logic [7:0] old_b;
    int ndone;

    for (int i = 0; i < 512; i++) mem[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(done == 1'b0, "R10 done", 32'(done), 0);
    chk(buf_we == 1'b0, "R10 buf_we", 32'(buf_we), 0);
    chk(status == 2'b00, "R10 status", 32'(status), 0);
    rst_n = 1'b1;

    // R1 packing
    raw_parity = 32'h0ABC0123; #1;
    chk(packed_code == 24'h543EDC, "R1 pack", 32'(packed_code), 32'h543EDC);
    raw_parity = 32'hF000F000; #1;
    chk(packed_code == 24'hFFFFFF, "R1 reserved", 32'(packed_code), 32'hFFFFFF);

    // Table walk
    for (int i = 0; i < NVEC; i++) begin
      vec_t v;
      bit exp_wr;
      v = VECS[i];
      exp_wr = (v.st == 2'b01) && v.fix;
      old_b = mem[v.byte_i];
      run_op(v.stored, v.raw, v.fix, lat, we_seen, we_addr);
      chk(status == v.st, "R2/R3/R6/R7 status", 32'(status), 32'(v.st));
      chk(lat == (exp_wr ? 2 : 1), "R2/R4/R5 done latency", 32'(lat), exp_wr ? 2 : 1);
      chk(we_seen == exp_wr, "R4/R5/R6/R7 buffer write", 32'(we_seen), 32'(exp_wr));
      if (v.st == 2'b01) begin
        chk(err_byte == v.byte_i, "R3 err_byte", 32'(err_byte), 32'(v.byte_i));
        chk(err_bit == v.bit_i, "R3 err_bit", 32'(err_bit), 32'(v.bit_i));
      end
      if (exp_wr) begin
        chk(we_addr == v.byte_i, "R4 buf_addr", 32'(we_addr), 32'(v.byte_i));
        chk(mem[v.byte_i] == (old_b ^ (8'd1 << v.bit_i)), "R4 repaired byte",
            32'(mem[v.byte_i]), 32'(old_b ^ (8'd1 << v.bit_i)));
      end else begin
        chk(mem[v.byte_i] == old_b, "R5 byte untouched", 32'(mem[v.byte_i]), 32'(old_b));
      end
      @(negedge clk);
      chk(done == 1'b0, "R9 done pulse", 32'(done), 0);
    end

    // R8 out-of-sector offsets on the 256-byte instance
    run_op(24'hABCEDC, 32'h0ABC0123, 1'b0, lat, we_seen, we_addr);
    chk(status_s == 2'b11, "R8 byte 511 small", 32'(status_s), 3);
    chk(status == 2'b01, "R8 byte 511 full", 32'(status), 1);
    run_op(24'hC21841, 32'h0ABC0123, 1'b0, lat, we_seen, we_addr);
    chk(status_s == 2'b11, "R8 byte 300 small", 32'(status_s), 3);
    run_op(24'h568108, 32'h0ABC0123, 1'b0, lat, we_seen, we_addr);
    chk(status_s == 2'b01, "R8 byte 5 small", 32'(status_s), 1);

    // R9 start while busy is ignored
    @(negedge clk);
    stored_code = 24'h568108; raw_parity = 32'h0ABC0123; fix_en = 1'b1; start = 1'b1;
    @(negedge clk);
    stored_code = 24'h543EDD;  // would be a code-bit error if accepted
    ndone = 0;
    @(negedge clk);
    start = 1'b0;
    if (done) ndone++;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      if (done) ndone++;
    end
    chk(ndone == 1, "R9 one done", 32'(ndone), 1);
    chk(status == 2'b01, "R9 result held", 32'(status), 1);

    finished = 1;
    summary();
    $finish;
  end

endmodule